// File: doc/BRIEF.md
# Configuration Mode Unlock Sequencer

This block watches the I/O write cycles of a host bus (address, byte of write data, write strobe) and decides when a peripheral controller may enter its configuration mode. Entry is a two-stage handshake. First, four bytes go to a fixed, write-only unlock port. Their last two bytes choose one of three index-port base addresses. Then a 32-byte key has to be written, byte by byte and in order, to the base that was just chosen. When the last key byte matches, the block raises its configuration flag and presents the chosen base. A register file downstream decodes that base. When software writes the exit command, the register file sends a one-cycle exit pulse, and the flag drops.

The sequencer is a six-state machine:
- `ST_IDLE`: nothing matched yet.
- `ST_PFX_A`: first unlock byte seen.
- `ST_PFX_B`: second unlock byte seen.
- `ST_PFX_C`: selector byte seen.
- `ST_KEY`: base chosen, key being checked.
- `ST_CONFIG`: unlocked.

Transitions:
- `go_pfx`: IDLE to PFX_A on 0x86.
- `pfx_next`: PFX_A to PFX_B on 0x80, and PFX_B to PFX_C on 0x55 or 0xAA.
- `pfx_done`: PFX_C to KEY on a legal selector pair.
- `key_step`: KEY to KEY on a matching key byte that is not the last.
- `key_done`: KEY to CONFIG on the last key byte.
- `abort`: any matching state to IDLE on a wrong byte.
- `rearm`: any matching state to PFX_A when the wrong byte is 0x86.
- `leave`: CONFIG to IDLE on the exit pulse.

The key bytes come from an 8-bit shift generator, not from a stored table.

Top module: `cfg_unlock_seq`

## Requirements
- R1: After reset, `cfg_mode` is 0, `base_valid` is 0 and `cfg_base` is 0x0000. `cfg_base` reads 0 whenever `base_valid` is 0.
- R2: The unlock bytes are written to address 0x0279 in this order: 0x86, 0x80, then a selector pair. The pair 0x55,0x55 selects base 0x3F0. The pair 0x55,0xAA selects base 0x3BD. The pair 0xAA,0x55 selects base 0x370. On the clock edge that takes the fourth byte, `base_valid` rises and `cfg_base` shows the selected base.
- R3: During the unlock stage, a wrong byte on 0x0279 returns the sequencer to idle with no base selected. This includes a selector pair of 0xAA,0xAA and a third byte that is neither 0x55 nor 0xAA.
- R4: The key is 32 bytes, written to the selected base. The first byte is 0x6A. Each later byte is the previous byte shifted right by one bit, with bit 7 set to bit 0 XOR bit 1 of the previous byte. The series ends 0xCE, 0xE7, 0x73, 0x39. `cfg_mode` rises on the edge that takes the 32nd matching byte.
- R5: While the key is in progress, `cfg_mode` stays 0, `base_valid` stays 1 and `cfg_base` holds the selected base. `cfg_mode` is never 1 while `base_valid` is 0.
- R6: In configuration mode, a one-cycle `exit_pulse` clears `cfg_mode`, `base_valid` and `cfg_base` on the next edge. In any other state, `exit_pulse` has no effect.
- R7: Cycles with `io_wr` low, and writes to any address other than the one the current state expects, leave the state unchanged. In the unlock stage the expected address is 0x0279. In the key stage it is the selected base.
- R8: A wrong key byte written to the selected base returns the sequencer to idle, and the base is deselected.
- R9: If a wrong unlock byte or wrong key byte equals 0x86, the sequencer counts it as the first unlock byte. In that case 0x80 and a selector pair are enough to finish the unlock stage.
- R10: In configuration mode, all writes, including a new unlock sequence, are ignored until `exit_pulse` arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O write address |
| io_wdata | input | 8 | I/O write data byte |
| io_wr | input | 1 | Write strobe, one cycle per write |
| exit_pulse | input | 1 | Exit command from the register file |
| cfg_mode | output | 1 | Configuration mode active |
| base_valid | output | 1 | A base address has been selected |
| cfg_base | output | 16 | Selected index-port base, 0 when none |

## Verification
A wrong state register shows at the ports on the edge right after the write that exposes it. If it sits in a key state too early or too late, `base_valid` or `cfg_base` is wrong the cycle after the fourth unlock byte. A key counter or generator that is off by one byte shows up as an abort to idle, or as a late `cfg_mode` rise, at the byte where it first diverges. The worst case is the 32nd write, which is why the bench checks the port values both one byte before the end of the key and at the end. A wrong re-arm or ignore decision stays hidden until the next unlock byte, so those cases are followed by a short completion sequence that makes the state visible.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PFX_A  = 3'd1,
        ST_PFX_B  = 3'd2,
        ST_PFX_C  = 3'd3,
        ST_KEY    = 3'd4,
        ST_CONFIG = 3'd5
    } unlock_state_t;

    localparam logic [7:0] UNLOCK_B0 = 8'h86;
    localparam logic [7:0] UNLOCK_B1 = 8'h80;
    localparam logic [7:0] SEL_LO    = 8'h55;
    localparam logic [7:0] SEL_HI    = 8'hAA;

    // Step of the key series: shift right, feed back bit0 ^ bit1 into bit 7.
    function automatic logic [7:0] key_next(input logic [7:0] cur);
        return {cur[0] ^ cur[1], cur[7:1]};
    endfunction

endpackage

// File: rtl/key_lfsr.sv
module key_lfsr #(
    parameter int          KEY_LEN  = 32,
    parameter logic [7:0]  KEY_SEED = 8'h6A,
    localparam int         CNT_W    = $clog2(KEY_LEN)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       advance,
    output logic [7:0] key_byte,
    output logic       key_last
);
    import cfg_unlock_pkg::*;

    logic [7:0]       cur_q;
    logic [CNT_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= KEY_SEED;
            idx_q <= '0;
        end else if (restart) begin
            cur_q <= KEY_SEED;
            idx_q <= '0;
        end else if (advance) begin
            cur_q <= key_next(cur_q);
            idx_q <= idx_q + 1'b1;
        end
    end

    assign key_byte = cur_q;
    assign key_last = (idx_q == CNT_W'(KEY_LEN - 1));

endmodule

// File: rtl/base_select.sv
module base_select #(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_0 = 16'h03F0,
    parameter logic [ADDR_W-1:0] BASE_1 = 16'h03BD,
    parameter logic [ADDR_W-1:0] BASE_2 = 16'h0370
) (
    input  logic              sel_hi,     // third unlock byte was SEL_HI
    input  logic [7:0]        fourth,
    output logic              pair_ok,
    output logic [ADDR_W-1:0] pair_base
);
    import cfg_unlock_pkg::*;

    always_comb begin
        pair_ok   = 1'b0;
        pair_base = '0;
        if (!sel_hi && fourth == SEL_LO) begin
            pair_ok   = 1'b1;
            pair_base = BASE_0;
        end else if (!sel_hi && fourth == SEL_HI) begin
            pair_ok   = 1'b1;
            pair_base = BASE_1;
        end else if (sel_hi && fourth == SEL_LO) begin
            pair_ok   = 1'b1;
            pair_base = BASE_2;
        end
    end

endmodule

// File: rtl/cfg_unlock_seq.sv
module cfg_unlock_seq #(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] UNLOCK_PORT = 16'h0279,
    parameter logic [ADDR_W-1:0] BASE_0      = 16'h03F0,
    parameter logic [ADDR_W-1:0] BASE_1      = 16'h03BD,
    parameter logic [ADDR_W-1:0] BASE_2      = 16'h0370,
    parameter int                KEY_LEN     = 32,
    parameter logic [7:0]        KEY_SEED    = 8'h6A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_wr,
    input  logic              exit_pulse,
    output logic              cfg_mode,
    output logic              base_valid,
    output logic [ADDR_W-1:0] cfg_base
);
    import cfg_unlock_pkg::*;

    unlock_state_t     state_q, state_d;
    logic              sel_hi_q, sel_hi_d;
    logic [ADDR_W-1:0] base_q, base_d;

    logic              unlock_hit, key_hit;
    logic [7:0]        key_byte;
    logic              key_last, key_restart, key_advance;
    logic              pair_ok;
    logic [ADDR_W-1:0] pair_base;
    unlock_state_t     miss_state;

    assign unlock_hit = io_wr && (io_addr == UNLOCK_PORT);
    assign key_hit    = io_wr && (io_addr == base_q);
    assign miss_state = (io_wdata == UNLOCK_B0) ? ST_PFX_A : ST_IDLE;

    key_lfsr #(
        .KEY_LEN  (KEY_LEN),
        .KEY_SEED (KEY_SEED)
    ) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (key_restart),
        .advance  (key_advance),
        .key_byte (key_byte),
        .key_last (key_last)
    );

    base_select #(
        .ADDR_W (ADDR_W),
        .BASE_0 (BASE_0),
        .BASE_1 (BASE_1),
        .BASE_2 (BASE_2)
    ) u_sel (
        .sel_hi    (sel_hi_q),
        .fourth    (io_wdata),
        .pair_ok   (pair_ok),
        .pair_base (pair_base)
    );

    // Next state and side registers
    always_comb begin
        state_d     = state_q;
        sel_hi_d    = sel_hi_q;
        base_d      = base_q;
        key_advance = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (unlock_hit && io_wdata == UNLOCK_B0) state_d = ST_PFX_A;
            end
            ST_PFX_A: begin
                if (unlock_hit) state_d = (io_wdata == UNLOCK_B1) ? ST_PFX_B : miss_state;
            end
            ST_PFX_B: begin
                if (unlock_hit) begin
                    if (io_wdata == SEL_LO || io_wdata == SEL_HI) begin
                        state_d  = ST_PFX_C;
                        sel_hi_d = (io_wdata == SEL_HI);
                    end else begin
                        state_d = miss_state;
                    end
                end
            end
            ST_PFX_C: begin
                if (unlock_hit) begin
                    if (pair_ok) begin
                        state_d = ST_KEY;
                        base_d  = pair_base;
                    end else begin
                        state_d = miss_state;
                    end
                end
            end
            ST_KEY: begin
                if (key_hit) begin
                    if (io_wdata == key_byte) begin
                        key_advance = 1'b1;
                        if (key_last) state_d = ST_CONFIG;
                    end else begin
                        state_d = miss_state;
                        base_d  = '0;
                    end
                end
            end
            ST_CONFIG: begin
                if (exit_pulse) begin
                    state_d = ST_IDLE;
                    base_d  = '0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign key_restart = (state_q != ST_KEY);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            sel_hi_q <= 1'b0;
            base_q   <= '0;
        end else begin
            state_q  <= state_d;
            sel_hi_q <= sel_hi_d;
            base_q   <= base_d;
        end
    end

    // Outputs
    always_comb begin
        cfg_mode   = (state_q == ST_CONFIG);
        base_valid = (state_q == ST_KEY) || (state_q == ST_CONFIG);
        cfg_base   = base_valid ? base_q : '0;
    end

endmodule

// File: rtl/cfg_unlock_chk.sv
module cfg_unlock_chk #(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_0 = 16'h03F0,
    parameter logic [ADDR_W-1:0] BASE_1 = 16'h03BD,
    parameter logic [ADDR_W-1:0] BASE_2 = 16'h0370
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic              exit_pulse,
    input logic              cfg_mode,
    input logic              base_valid,
    input logic [ADDR_W-1:0] cfg_base
);

    assert_zero_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !base_valid |-> cfg_base == '0);

    assert_legal_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        base_valid |-> (cfg_base == BASE_0 || cfg_base == BASE_1 || cfg_base == BASE_2));

    assert_mode_has_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode |-> base_valid);

    assert_exit_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && exit_pulse) |=> (!cfg_mode && !base_valid));

    assert_no_write_no_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_wr && !exit_pulse) |=> ($stable(cfg_mode) && $stable(base_valid) && $stable(cfg_base)));

    assert_config_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && !exit_pulse) |=> (cfg_mode && $stable(cfg_base)));

    assert_mode_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && !io_wr) |=> !cfg_mode);

endmodule

bind cfg_unlock_seq cfg_unlock_chk #(
    .ADDR_W (ADDR_W),
    .BASE_0 (BASE_0),
    .BASE_1 (BASE_1),
    .BASE_2 (BASE_2)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_wr      (io_wr),
    .exit_pulse (exit_pulse),
    .cfg_mode   (cfg_mode),
    .base_valid (base_valid),
    .cfg_base   (cfg_base)
);

// File: tb/sim_cfg_unlock_seq.sv
`timescale 1ns/1ps
module sim_cfg_unlock_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        exit_pulse = 1'b0;
    logic        cfg_mode;
    logic        base_valid;
    logic [15:0] cfg_base;

    always #2 clk = ~clk;

    cfg_unlock_seq u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_addr    (io_addr),
        .io_wdata   (io_wdata),
        .io_wr      (io_wr),
        .exit_pulse (exit_pulse),
        .cfg_mode   (cfg_mode),
        .base_valid (base_valid),
        .cfg_base   (cfg_base)
    );

    localparam logic [15:0] PORT = 16'h0279;
    localparam logic [7:0] KEY [32] = '{
        8'h6A, 8'hB5, 8'hDA, 8'hED, 8'hF6, 8'hFB, 8'h7D, 8'hBE,
        8'hDF, 8'h6F, 8'h37, 8'h1B, 8'h0D, 8'h86, 8'hC3, 8'h61,
        8'hB0, 8'h58, 8'h2C, 8'h16, 8'h8B, 8'h45, 8'hA2, 8'hD1,
        8'hE8, 8'h74, 8'h3A, 8'h9D, 8'hCE, 8'hE7, 8'h73, 8'h39
    };

    typedef struct {
        string       tag;
        bit          mode;
        bit          valid;
        logic [15:0] base;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Monitor: pops one expected item per falling edge and compares
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (cfg_mode !== e.mode || base_valid !== e.valid || cfg_base !== e.base) begin
                    n_fail++;
                    $display("FAIL %s: got mode=%0b valid=%0b base=%h, expected mode=%0b valid=%0b base=%h",
                             e.tag, cfg_mode, base_valid, cfg_base, e.mode, e.valid, e.base);
                end
            end
        end
    end

    task automatic expect_out(input string tag, input bit m, input bit v, input logic [15:0] b);
        exp_t e;
        e.tag = tag; e.mode = m; e.valid = v; e.base = b;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic idle_cycle(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_exit();
        @(negedge clk);
        exit_pulse = 1'b1;
        @(negedge clk);
        exit_pulse = 1'b0;
    endtask

    task automatic prefix(input logic [7:0] s0, input logic [7:0] s1);
        wr(PORT, 8'h86); wr(PORT, 8'h80); wr(PORT, s0); wr(PORT, s1);
    endtask

    task automatic keys(input logic [15:0] b, input int first, input int last);
        for (int i = first; i <= last; i++) wr(b, KEY[i]);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_out("R1 reset", 0, 0, 16'h0000);

        // R2/R4/R5: unlock at 0x3F0
        prefix(8'h55, 8'h55);
        expect_out("R2 base 3F0 after prefix", 0, 1, 16'h03F0);
        keys(16'h03F0, 0, 30);
        expect_out("R5 no mode before last key", 0, 1, 16'h03F0);
        keys(16'h03F0, 31, 31);
        expect_out("R4 mode after 32 keys", 1, 1, 16'h03F0);

        // R10: writes in config ignored
        prefix(8'hAA, 8'h55);
        wr(16'h03F0, 8'h00);
        expect_out("R10 config ignores writes", 1, 1, 16'h03F0);

        // R6: exit
        send_exit();
        expect_out("R6 exit clears", 0, 0, 16'h0000);

        // R6: exit outside config has no effect (key stage)
        prefix(8'h55, 8'hAA);
        send_exit();
        expect_out("R6 exit ignored in key stage", 0, 1, 16'h03BD);
        // R7: interleaved foreign writes and strobe-less cycles in key stage
        keys(16'h03BD, 0, 9);
        wr(PORT, 8'h00);
        wr(16'h03F0, 8'h11);
        idle_cycle(16'h03BD, 8'h00);
        expect_out("R7 foreign writes ignored in key", 0, 1, 16'h03BD);
        keys(16'h03BD, 10, 31);
        expect_out("R2 R4 unlock at 3BD", 1, 1, 16'h03BD);
        send_exit();
        expect_out("R6 exit from 3BD", 0, 0, 16'h0000);

        // R7: foreign writes during unlock stage
        wr(PORT, 8'h86);
        wr(16'h03F0, 8'h80);
        idle_cycle(PORT, 8'h33);
        wr(PORT, 8'h80);
        wr(16'h0370, 8'h12);
        wr(PORT, 8'hAA);
        wr(PORT, 8'h55);
        expect_out("R7 R2 base 370 through noise", 0, 1, 16'h0370);
        keys(16'h0370, 0, 31);
        expect_out("R4 unlock at 370", 1, 1, 16'h0370);
        send_exit();
        expect_out("R6 exit from 370", 0, 0, 16'h0000);

        // R3: illegal pair AA/AA, then follow with selector to prove idle
        prefix(8'hAA, 8'hAA);
        expect_out("R3 AA/AA aborts", 0, 0, 16'h0000);
        wr(PORT, 8'h80); wr(PORT, 8'h55); wr(PORT, 8'h55);
        expect_out("R3 idle after abort", 0, 0, 16'h0000);
        // R3: bad third byte
        wr(PORT, 8'h86); wr(PORT, 8'h80); wr(PORT, 8'h77); wr(PORT, 8'h55);
        expect_out("R3 bad third byte aborts", 0, 0, 16'h0000);

        // R8: key mismatch
        prefix(8'h55, 8'h55);
        keys(16'h03F0, 0, 9);
        wr(16'h03F0, 8'h00);
        expect_out("R8 key mismatch deselects", 0, 0, 16'h0000);
        wr(16'h03F0, KEY[10]);
        expect_out("R8 key stays aborted", 0, 0, 16'h0000);

        // R9: re-arm in unlock stage
        wr(PORT, 8'h86); wr(PORT, 8'h80); wr(PORT, 8'h86);
        wr(PORT, 8'h80); wr(PORT, 8'hAA); wr(PORT, 8'h55);
        expect_out("R9 rearm in unlock stage", 0, 1, 16'h0370);
        // R9: re-arm from key stage
        keys(16'h0370, 0, 4);
        wr(16'h0370, 8'h86);
        expect_out("R9 key miss deselects", 0, 0, 16'h0000);
        wr(PORT, 8'h80); wr(PORT, 8'h55); wr(PORT, 8'h55);
        expect_out("R9 rearm from key stage", 0, 1, 16'h03F0);
        keys(16'h03F0, 0, 31);
        expect_out("R4 unlock after rearm", 1, 1, 16'h03F0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule